// File: doc/BRIEF.md
# Page-entry reload sequencer

After a translation miss, this block fetches one page-directory or page-table entry on behalf of the translation buffer. A request carries the physical address of the entry. It also carries a flag confirming that the pipeline has been serialized. Only a serialized request is ever started, so no reload happens speculatively.

An accepted reload runs in a fixed order:
1. The block snoops the data cache's physical tags at the entry address.
2. If the snoop reports a modified line, the block orders a write-back of that line and waits for it to finish.
3. The block then reads the entry from memory with the non-cacheable attribute. It does this even when the cache holds a copy.

The 32-bit entry is returned on the fill port for one cycle. Snoop, write-back and read each use a request/acknowledge handshake whose latency can vary.

Top module: `pte_reload_seq`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, busy, proto_err, snp_req, wb_req, rd_req and fill_valid are all 0.
- R2: When the block is idle, a request with req_valid=1 and req_serial=1 is accepted. On the next cycle busy=1, snp_req=1 and snp_addr equals the requested address.
- R3: A request with req_valid=1 and req_serial=0 starts nothing: busy and snp_req stay 0. proto_err is 1 for exactly the one cycle after that request.
- R4: Requests that arrive while busy=1 are ignored. The captured address seen on snp_addr and rd_addr does not change, and no second sequence follows.
- R5: snp_req, wb_req and rd_req each stay at 1 until the cycle in which the matching acknowledge is sampled. Each drops on the following cycle.
- R6: A snoop acknowledge with snp_hit_mod=1 raises wb_req on the next cycle. wb_addr is the entry address with its low LINE_W bits cleared. rd_req stays 0 until wb_ack is sampled.
- R7: A snoop acknowledge with snp_hit_mod=0 raises rd_req on the next cycle, and no write-back is issued.
- R8: Every reload performs a memory read: rd_addr is the entry address and rd_uncached=1 while rd_req=1.
- R9: The cycle after rd_ack, fill_valid=1 for one cycle and fill_data carries the rd_data sampled with rd_ack. The cycle after that, busy=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Reload request strobe |
| req_serial | input | 1 | Request is issued after pipeline serialization |
| req_addr | input | ADDR_W | Physical address of the entry |
| busy | output | 1 | A reload sequence is in progress |
| proto_err | output | 1 | Pulse: a non-serialized request was seen |
| snp_req | output | 1 | Tag snoop request |
| snp_addr | output | ADDR_W | Snoop address |
| snp_ack | input | 1 | Snoop completed |
| snp_hit_mod | input | 1 | Snoop found a modified line (valid with snp_ack) |
| wb_req | output | 1 | Write-back request |
| wb_addr | output | ADDR_W | Line-aligned write-back address |
| wb_ack | input | 1 | Write-back completed |
| rd_req | output | 1 | Memory read request |
| rd_addr | output | ADDR_W | Read address |
| rd_uncached | output | 1 | Read must bypass caches |
| rd_ack | input | 1 | Read data valid |
| rd_data | input | DATA_W | Entry returned by memory |
| fill_valid | output | 1 | Entry ready for the translation buffer |
| fill_data | output | DATA_W | Entry value |

## Verification
Each result is due a fixed number of cycles after the stimulus that causes it:
- One cycle after acceptance: the snoop request.
- One cycle after the sampled acknowledge: the next handshake request.
- One cycle after the read acknowledge: the fill.
- One cycle after the fill: the return to idle.
- One cycle after a non-serialized request: the error pulse.

The bench drives and samples only on falling edges. It steps exactly one falling edge per register in the path before it compares. Throughout each randomized handshake wait, it checks that the pending request holds and that the others stay low.

// File: rtl/prl_pkg.sv
package prl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SNOOP = 3'd1,
    ST_WBACK = 3'd2,
    ST_READ  = 3'd3,
    ST_DONE  = 3'd4
  } prl_state_e;
endpackage

// File: rtl/prl_intake.sv
module prl_intake (
  input  logic clk,
  input  logic rst,
  input  logic req_valid,
  input  logic req_serial,
  input  logic idle,
  output logic accept,
  output logic proto_err
);
  assign accept = req_valid & req_serial & idle;

  always_ff @(posedge clk) begin
    if (rst) proto_err <= 1'b0;
    else     proto_err <= req_valid & ~req_serial;
  end

  // R3
  err_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_serial) |=> proto_err);
endmodule

// File: rtl/prl_regs.sv
module prl_regs #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LINE_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              load_data,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] addr_q,
  output logic [ADDR_W-1:0] line_addr,
  output logic [DATA_W-1:0] data_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      data_q <= '0;
    end else begin
      if (accept)    addr_q <= req_addr;
      if (load_data) data_q <= rd_data;
    end
  end

  generate
    if (LINE_W > 0) begin : g_align
      assign line_addr = {addr_q[ADDR_W-1:LINE_W], {LINE_W{1'b0}}};
    end else begin : g_noalign
      assign line_addr = addr_q;
    end
  endgenerate

  // R4
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !accept |=> $stable(addr_q));
endmodule

// File: rtl/prl_ctrl.sv
module prl_ctrl
  import prl_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic accept,
  input  logic req_valid,
  input  logic req_serial,
  input  logic snp_ack,
  input  logic snp_hit_mod,
  input  logic wb_ack,
  input  logic rd_ack,
  output logic busy,
  output logic snp_req,
  output logic wb_req,
  output logic rd_req,
  output logic fill_valid,
  output logic load_data
);
  prl_state_e st, st_nx;

  always_comb begin
    st_nx = st;
    case (st)
      ST_IDLE:  if (accept)  st_nx = ST_SNOOP;
      ST_SNOOP: if (snp_ack) st_nx = snp_hit_mod ? ST_WBACK : ST_READ;
      ST_WBACK: if (wb_ack)  st_nx = ST_READ;
      ST_READ:  if (rd_ack)  st_nx = ST_DONE;
      ST_DONE:               st_nx = ST_IDLE;
      default:               st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st <= ST_IDLE;
    else     st <= st_nx;
  end

  assign busy       = (st != ST_IDLE);
  assign snp_req    = (st == ST_SNOOP);
  assign wb_req     = (st == ST_WBACK);
  assign rd_req     = (st == ST_READ);
  assign fill_valid = (st == ST_DONE);
  assign load_data  = rd_req & rd_ack;

  // R2
  start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(req_valid && req_serial));
  // R5
  snp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (snp_req && !snp_ack) |=> snp_req);
  // R5
  wb_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wb_req && !wb_ack) |=> wb_req);
  // R5
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !rd_ack) |=> rd_req);
  // R6
  wb_after_hit_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(wb_req) |-> $past(snp_ack && snp_hit_mod));
  // R7
  clean_to_read_chk: assert property (@(posedge clk) disable iff (rst)
    (snp_req && snp_ack && !snp_hit_mod) |=> (rd_req && !wb_req));
  // R9
  fill_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    fill_valid |=> (!fill_valid && !busy));
endmodule

// File: rtl/pte_reload_seq.sv
module pte_reload_seq #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LINE_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_serial,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              busy,
  output logic              proto_err,
  output logic              snp_req,
  output logic [ADDR_W-1:0] snp_addr,
  input  logic              snp_ack,
  input  logic              snp_hit_mod,
  output logic              wb_req,
  output logic [ADDR_W-1:0] wb_addr,
  input  logic              wb_ack,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              rd_uncached,
  input  logic              rd_ack,
  input  logic [DATA_W-1:0] rd_data,
  output logic              fill_valid,
  output logic [DATA_W-1:0] fill_data
);
  logic accept, load_data;
  logic [ADDR_W-1:0] addr_q, line_addr;

  prl_intake u_intake (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_serial(req_serial),
    .idle(!busy), .accept(accept), .proto_err(proto_err)
  );

  prl_ctrl u_ctrl (
    .clk(clk), .rst(rst), .accept(accept), .req_valid(req_valid),
    .req_serial(req_serial), .snp_ack(snp_ack), .snp_hit_mod(snp_hit_mod),
    .wb_ack(wb_ack), .rd_ack(rd_ack), .busy(busy), .snp_req(snp_req),
    .wb_req(wb_req), .rd_req(rd_req), .fill_valid(fill_valid),
    .load_data(load_data)
  );

  prl_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_W(LINE_W)) u_regs (
    .clk(clk), .rst(rst), .accept(accept), .req_addr(req_addr),
    .load_data(load_data), .rd_data(rd_data), .addr_q(addr_q),
    .line_addr(line_addr), .data_q(fill_data)
  );

  assign snp_addr    = addr_q;
  assign wb_addr     = line_addr;
  assign rd_addr     = addr_q;
  assign rd_uncached = 1'b1;
endmodule

// File: tb/tb_pte_reload_seq.sv
module tb_pte_reload_seq;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int LINE_W = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_serial = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic busy, proto_err, snp_req, wb_req, rd_req, rd_uncached, fill_valid;
  logic [ADDR_W-1:0] snp_addr, wb_addr, rd_addr;
  logic snp_ack = 1'b0, snp_hit_mod = 1'b0, wb_ack = 1'b0, rd_ack = 1'b0;
  logic [DATA_W-1:0] rd_data = '0;
  logic [DATA_W-1:0] fill_data;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pte_reload_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_W(LINE_W)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_serial(req_serial),
    .req_addr(req_addr), .busy(busy), .proto_err(proto_err),
    .snp_req(snp_req), .snp_addr(snp_addr), .snp_ack(snp_ack),
    .snp_hit_mod(snp_hit_mod), .wb_req(wb_req), .wb_addr(wb_addr),
    .wb_ack(wb_ack), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_uncached(rd_uncached), .rd_ack(rd_ack), .rd_data(rd_data),
    .fill_valid(fill_valid), .fill_data(fill_data)
  );

  function automatic logic [ADDR_W-1:0] exp_line(input logic [ADDR_W-1:0] a);
    return a & ~((ADDR_W'(1) << LINE_W) - ADDR_W'(1));
  endfunction

  task automatic chk(input bit ok, input string tag,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle_outputs(input string tag);
    chk(!busy && !snp_req && !wb_req && !rd_req && !fill_valid, tag,
        {busy, snp_req, wb_req, rd_req, fill_valid}, 0);
  endtask

  task automatic reload(input logic [ADDR_W-1:0] a, input bit hit,
                        input int ls, input int lw, input int lr,
                        input logic [DATA_W-1:0] d, input bit inject);
    @(negedge clk);
    req_valid = 1'b1; req_serial = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy && snp_req, "R2 start", {busy, snp_req}, 2'b11);
    chk(snp_addr == a, "R2 snoop addr", snp_addr, a);
    for (int i = 0; i < ls; i++) begin
      if (inject && i == 0) begin
        req_valid = 1'b1; req_addr = ~a;
      end
      @(negedge clk);
      req_valid = 1'b0;
      chk(snp_req && !wb_req && !rd_req, "R5 snoop held",
          {snp_req, wb_req, rd_req}, 3'b100);
      chk(snp_addr == a, "R4 addr kept", snp_addr, a);
    end
    snp_ack = 1'b1; snp_hit_mod = hit;
    @(negedge clk);
    snp_ack = 1'b0; snp_hit_mod = 1'b0;
    chk(!snp_req, "R5 snoop drop", snp_req, 0);
    if (hit) begin
      chk(wb_req && !rd_req, "R6 writeback", {wb_req, rd_req}, 2'b10);
      chk(wb_addr == exp_line(a), "R6 line addr", wb_addr, exp_line(a));
      for (int i = 0; i < lw; i++) begin
        @(negedge clk);
        chk(wb_req && !rd_req, "R6 wait wb", {wb_req, rd_req}, 2'b10);
      end
      wb_ack = 1'b1;
      @(negedge clk);
      wb_ack = 1'b0;
      chk(!wb_req, "R5 wb drop", wb_req, 0);
    end else begin
      chk(!wb_req, "R7 no writeback", wb_req, 0);
    end
    chk(rd_req && rd_uncached, "R8 read uncached", {rd_req, rd_uncached}, 2'b11);
    chk(rd_addr == a, "R8 read addr", rd_addr, a);
    for (int i = 0; i < lr; i++) begin
      @(negedge clk);
      chk(rd_req && !fill_valid, "R5 read held", {rd_req, fill_valid}, 2'b10);
    end
    rd_ack = 1'b1; rd_data = d;
    @(negedge clk);
    rd_ack = 1'b0; rd_data = ~d;
    chk(fill_valid && !rd_req, "R9 fill valid", {fill_valid, rd_req}, 2'b10);
    chk(fill_data == d, "R9 fill data", fill_data, d);
    @(negedge clk);
    chk(!fill_valid && !busy, "R9 back idle", {fill_valid, busy}, 0);
    if (inject) idle_outputs("R4 no second sequence");
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (2) @(posedge clk);
    while (!done) begin
      @(posedge clk);
      if (n_chk >= 0 && $time > 400000 * CLK_PERIOD / 10) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        summary();
      end
    end
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (2) @(negedge clk);
    idle_outputs("R1 during reset");
    chk(!proto_err, "R1 err in reset", proto_err, 0);
    rst = 1'b0;
    @(negedge clk);
    idle_outputs("R1 after reset");
    chk(!proto_err, "R1 err after reset", proto_err, 0);

    // directed: non-serialized request (R3)
    @(negedge clk);
    req_valid = 1'b1; req_serial = 1'b0; req_addr = 32'h0000_1234;
    @(negedge clk);
    req_valid = 1'b0;
    chk(proto_err, "R3 error pulse", proto_err, 1);
    chk(!busy && !snp_req, "R3 not started", {busy, snp_req}, 0);
    @(negedge clk);
    chk(!proto_err, "R3 single pulse", proto_err, 0);
    idle_outputs("R3 stays idle");

    // directed corners
    reload(32'hFFFF_FFFC, 1'b1, 0, 0, 0, 32'hDEAD_BEEF, 1'b0);
    reload(32'h0000_0000, 1'b0, 0, 0, 0, 32'h0000_0001, 1'b0);
    reload(32'h1234_567C, 1'b1, 3, 4, 2, 32'hA5A5_5A5A, 1'b1);
    reload(32'h0040_0FE4, 1'b0, 2, 0, 5, 32'h0BAD_F00D, 1'b1);

    // randomized
    for (int n = 0; n < 60; n++) begin
      reload({$urandom} & 32'hFFFF_FFFC, 1'($urandom % 2),
             int'($urandom % 5), int'($urandom % 5), int'($urandom % 5),
             $urandom, 1'($urandom % 4 == 0));
    end
    done = 1'b1;
    summary();
  end
endmodule